// File: doc/BRIEF.md
# Shared Test-Pin Mode Controller

This block decides whether the three test pins of a device (test clock, test data in, test data out) serve the boundary-scan logic or act as ordinary user I/O. It holds a standard 16-state test access port (TAP) controller that advances on the rising edge of the test clock under control of the mode-select input. It also holds a one-bit mode register. The mode register claims the pins for test use when mode-select is seen low. It hands the pins back when the TAP falls into its reset state.

A static strap input picks between two modes. In shared (flexible) mode the claim/release behaviour above applies. In dedicated mode the pins always belong to test, and the TAP follows the standard exactly. The block gives out:
- a test-enable per pin and the matching user-path mux selects;
- the TAP state as a binary code and as a one-hot vector;
- a test-data-out pad driver that is launched on the falling edge and enabled only while a shift state is active.

The scan cells, instruction decoding and pad cells sit outside. The block's reset is synchronous and active-high, and it is sampled on the test clock.

Top module: `jtag_pin_share`

## Requirements
- R1: In shared mode (`dedicated_mode`=0), a rising edge of `tck` that samples `tms`=0 while `test_active` is 0 sets `test_active` to 1 after that edge.
- R2: Once `test_active` is 1 in shared mode, it stays 1 on every edge after which the TAP state is not Test-Logic-Reset.
- R3: `tap_state` follows the standard TAP transitions on each `tck` rising edge. The codes are: Test-Logic-Reset 0, Run-Test/Idle 1, Select-DR 2, Capture-DR 3, Shift-DR 4, Exit1-DR 5, Pause-DR 6, Exit2-DR 7, Update-DR 8, Select-IR 9, Capture-IR 10, Shift-IR 11, Exit1-IR 12, Pause-IR 13, Exit2-IR 14, Update-IR 15.
- R4: Five consecutive rising edges that sample `tms`=1 put the TAP in Test-Logic-Reset (code 0) from any state. In shared mode, `test_active` goes to 0 on the same edge on which the TAP enters Test-Logic-Reset.
- R5: With `dedicated_mode`=1, `test_active` is 1 and `pin_test_en` is all ones at all times after reset, including in Test-Logic-Reset.
- R6: Each falling edge of `tck` captures `scan_tdo` and a drive flag. The flag is 1 only if the TAP state is Shift-DR (4) or Shift-IR (11) and `test_active` is 1. While `test_active` is 1, `tdo_pad_out`/`tdo_pad_oe` show the captured value and flag. While it is 0, they follow `user_tdo_out`/`user_tdo_oe`.
- R7: `rst`=1 at a rising edge puts the TAP in Test-Logic-Reset and clears `test_active` in shared mode. `rst`=1 at a falling edge clears the captured TDO value and drive flag.
- R8: `tap_onehot` has exactly one bit set, at the index equal to `tap_state`.
- R9: Every bit of `pin_test_en` equals `test_active`. Every bit of `user_sel` is its inverse. `scan_tdi` equals `tdi_pad` while `test_active` is 1 and is 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| dedicated_mode | input | 1 | Static strap: 1 = pins always for test |
| tms | input | 1 | Test mode select |
| tdi_pad | input | 1 | Value seen on the test-data-in pin |
| scan_tdo | input | 1 | Serial data from the scan chain |
| user_tdo_out | input | 1 | User output value for the TDO pin |
| user_tdo_oe | input | 1 | User output enable for the TDO pin |
| tdo_pad_out | output | 1 | Data driven to the TDO pad |
| tdo_pad_oe | output | 1 | Output enable for the TDO pad |
| scan_tdi | output | 1 | Test data into the scan chain |
| pin_test_en | output | 3 | Per-pin test enable (TCK, TDI, TDO) |
| user_sel | output | 3 | Per-pin user I/O path select |
| test_active | output | 1 | Pins currently owned by test logic |
| tap_state | output | 4 | TAP state code |
| tap_onehot | output | 16 | One-hot TAP state |

## Verification
The bench drives the mode-select input low for the first time from the idle reset state and expects the claim after that edge. A design that claims one edge late, or that claims on a high level, shows a wrong `test_active` there. It walks into Shift-DR and then gives five high mode-select edges. After the fourth edge (Select-IR) the pins must still be held, and they must be freed only after the fifth. A release off by one edge shows up on one of those two edges. Long random mode-select runs cover every TAP arc and the TDO drive window at the falling edge. These runs catch a drive window shifted by half a cycle and a pad that drives outside the shift states. The strap is changed under reset, which catches a dedicated mode that still lets the pins go in Test-Logic-Reset.

// File: rtl/jps_pkg.sv
package jps_pkg;

  localparam int TAP_STATES = 16;
  localparam int TAP_W      = $clog2(TAP_STATES);
  localparam int NUM_PINS   = 3;

  typedef enum logic [TAP_W-1:0] {
    ST_TLR    = 4'd0,
    ST_RTI    = 4'd1,
    ST_SEL_DR = 4'd2,
    ST_CAP_DR = 4'd3,
    ST_SH_DR  = 4'd4,
    ST_E1_DR  = 4'd5,
    ST_PA_DR  = 4'd6,
    ST_E2_DR  = 4'd7,
    ST_UP_DR  = 4'd8,
    ST_SEL_IR = 4'd9,
    ST_CAP_IR = 4'd10,
    ST_SH_IR  = 4'd11,
    ST_E1_IR  = 4'd12,
    ST_PA_IR  = 4'd13,
    ST_E2_IR  = 4'd14,
    ST_UP_IR  = 4'd15
  } tap_state_e;

  function automatic tap_state_e tap_step(tap_state_e cur, logic sel);
    tap_state_e nx;
    case (cur)
      ST_TLR:    nx = sel ? ST_TLR    : ST_RTI;
      ST_RTI:    nx = sel ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nx = sel ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nx = sel ? ST_E1_DR  : ST_SH_DR;
      ST_SH_DR:  nx = sel ? ST_E1_DR  : ST_SH_DR;
      ST_E1_DR:  nx = sel ? ST_UP_DR  : ST_PA_DR;
      ST_PA_DR:  nx = sel ? ST_E2_DR  : ST_PA_DR;
      ST_E2_DR:  nx = sel ? ST_UP_DR  : ST_SH_DR;
      ST_UP_DR:  nx = sel ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nx = sel ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nx = sel ? ST_E1_IR  : ST_SH_IR;
      ST_SH_IR:  nx = sel ? ST_E1_IR  : ST_SH_IR;
      ST_E1_IR:  nx = sel ? ST_UP_IR  : ST_PA_IR;
      ST_PA_IR:  nx = sel ? ST_E2_IR  : ST_PA_IR;
      ST_E2_IR:  nx = sel ? ST_UP_IR  : ST_SH_IR;
      default:   nx = sel ? ST_SEL_DR : ST_RTI;
    endcase
    return nx;
  endfunction

endpackage

// File: rtl/jps_tap_fsm.sv
module jps_tap_fsm
  import jps_pkg::*;
#(
  parameter int RESET_RUN = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tms,
  output tap_state_e            state_o,
  output logic                  nxt_is_tlr_o,
  output logic [TAP_STATES-1:0] onehot_o
);

  localparam int CNT_W = $clog2(RESET_RUN + 1);
  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(RESET_RUN);

  tap_state_e            state_q, state_d;
  logic [TAP_STATES-1:0] onehot_q;
  logic [CNT_W-1:0]      high_run_q;

  always_comb state_d = tap_step(state_q, tms);

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_TLR;
    else     state_q <= state_d;
  end

  for (genvar i = 0; i < TAP_STATES; i++) begin : g_onehot
    always_ff @(posedge clk) begin
      if (rst) onehot_q[i] <= (i == 0);
      else     onehot_q[i] <= (state_d == tap_state_e'(i));
    end
  end

  // length of the current run of high mode-select samples, saturating
  always_ff @(posedge clk) begin
    if (rst)                  high_run_q <= '0;
    else if (!tms)            high_run_q <= '0;
    else if (high_run_q != RUN_MAX) high_run_q <= high_run_q + 1'b1;
  end

  assign state_o      = state_q;
  assign onehot_o     = onehot_q;
  assign nxt_is_tlr_o = (state_d == ST_TLR);

  p_five_high_to_tlr_r4: assert property (@(posedge clk) disable iff (rst)
    (high_run_q == RUN_MAX) |-> (state_q == ST_TLR));

  p_onehot_single_r8: assert property (@(posedge clk) disable iff (rst)
    ($countones(onehot_q) == 1) && onehot_q[state_q]);

endmodule

// File: rtl/jps_mode_reg.sv
module jps_mode_reg
  import jps_pkg::*;
#(
  parameter int PINS = NUM_PINS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dedicated,
  input  logic            tms,
  input  logic            nxt_is_tlr,
  input  logic            cur_is_tlr,
  output logic            active_o,
  output logic [PINS-1:0] pin_en_o,
  output logic [PINS-1:0] user_sel_o
);

  logic claim_q;

  always_ff @(posedge clk) begin
    if (rst)                  claim_q <= 1'b0;
    else if (nxt_is_tlr)      claim_q <= 1'b0;
    else if (!claim_q && !tms) claim_q <= 1'b1;
  end

  assign active_o = claim_q | dedicated;

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    assign pin_en_o[p]   = active_o;
    assign user_sel_o[p] = ~active_o;
  end

  p_claim_on_low_r1: assert property (@(posedge clk) disable iff (rst)
    (!dedicated && !claim_q && !tms) |=> claim_q);

  p_release_only_in_tlr_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(claim_q) |-> cur_is_tlr);

  p_free_in_tlr_r4: assert property (@(posedge clk) disable iff (rst)
    (!dedicated && cur_is_tlr) |-> !active_o);

  p_dedicated_owns_r5: assert property (@(posedge clk) disable iff (rst)
    dedicated |-> (&pin_en_o));

endmodule

// File: rtl/jps_tdo_launch.sv
module jps_tdo_launch
  import jps_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  tap_state_e state,
  input  logic       active,
  input  logic       scan_tdo,
  input  logic       user_out,
  input  logic       user_oe,
  output logic       pad_out,
  output logic       pad_oe
);

  logic data_q, drive_q;
  logic in_shift;

  assign in_shift = (state == ST_SH_DR) || (state == ST_SH_IR);

  always_ff @(negedge clk) begin
    if (rst) begin
      data_q  <= 1'b0;
      drive_q <= 1'b0;
    end else begin
      data_q  <= scan_tdo;
      drive_q <= in_shift && active;
    end
  end

  assign pad_out = active ? data_q  : user_out;
  assign pad_oe  = active ? drive_q : user_oe;

  p_drive_needs_shift_r6: assert property (@(negedge clk) disable iff (rst)
    (active && in_shift) |=> drive_q);

endmodule

// File: rtl/jtag_pin_share.sv
module jtag_pin_share
  import jps_pkg::*;
(
  input  logic                  tck,
  input  logic                  rst,
  input  logic                  dedicated_mode,
  input  logic                  tms,
  input  logic                  tdi_pad,
  input  logic                  scan_tdo,
  input  logic                  user_tdo_out,
  input  logic                  user_tdo_oe,
  output logic                  tdo_pad_out,
  output logic                  tdo_pad_oe,
  output logic                  scan_tdi,
  output logic [NUM_PINS-1:0]   pin_test_en,
  output logic [NUM_PINS-1:0]   user_sel,
  output logic                  test_active,
  output logic [TAP_W-1:0]      tap_state,
  output logic [TAP_STATES-1:0] tap_onehot
);

  tap_state_e st;
  logic       nxt_tlr;

  jps_tap_fsm #(.RESET_RUN(5)) u_fsm (
    .clk          (tck),
    .rst          (rst),
    .tms          (tms),
    .state_o      (st),
    .nxt_is_tlr_o (nxt_tlr),
    .onehot_o     (tap_onehot)
  );

  jps_mode_reg #(.PINS(NUM_PINS)) u_mode (
    .clk        (tck),
    .rst        (rst),
    .dedicated  (dedicated_mode),
    .tms        (tms),
    .nxt_is_tlr (nxt_tlr),
    .cur_is_tlr (st == ST_TLR),
    .active_o   (test_active),
    .pin_en_o   (pin_test_en),
    .user_sel_o (user_sel)
  );

  jps_tdo_launch u_tdo (
    .clk      (tck),
    .rst      (rst),
    .state    (st),
    .active   (test_active),
    .scan_tdo (scan_tdo),
    .user_out (user_tdo_out),
    .user_oe  (user_tdo_oe),
    .pad_out  (tdo_pad_out),
    .pad_oe   (tdo_pad_oe)
  );

  assign tap_state = st;
  assign scan_tdi  = test_active ? tdi_pad : 1'b1;

endmodule

// File: tb/tb_jtag_pin_share.sv
module tb_jtag_pin_share;
  localparam int CLK_PERIOD = 10;

  logic tck = 1'b0, rst = 1'b1, dedicated_mode = 1'b0, tms = 1'b1;
  logic tdi_pad = 1'b0, scan_tdo = 1'b0, user_tdo_out = 1'b0, user_tdo_oe = 1'b0;
  logic tdo_pad_out, tdo_pad_oe, scan_tdi, test_active;
  logic [2:0]  pin_test_en, user_sel;
  logic [3:0]  tap_state;
  logic [15:0] tap_onehot;

  jtag_pin_share dut (.*);

  always #(CLK_PERIOD/2) tck = ~tck;

  int total = 0, bad = 0;
  bit done = 0;
  logic [3:0] m_st;
  logic m_claim, m_dq, m_de;

  function automatic logic [3:0] nxt(logic [3:0] s, logic t);
    case (s)
      4'd0:  return t ? 4'd0  : 4'd1;
      4'd1:  return t ? 4'd2  : 4'd1;
      4'd2:  return t ? 4'd9  : 4'd3;
      4'd3:  return t ? 4'd5  : 4'd4;
      4'd4:  return t ? 4'd5  : 4'd4;
      4'd5:  return t ? 4'd8  : 4'd6;
      4'd6:  return t ? 4'd7  : 4'd6;
      4'd7:  return t ? 4'd8  : 4'd4;
      4'd8:  return t ? 4'd2  : 4'd1;
      4'd9:  return t ? 4'd0  : 4'd10;
      4'd10: return t ? 4'd12 : 4'd11;
      4'd11: return t ? 4'd12 : 4'd11;
      4'd12: return t ? 4'd15 : 4'd13;
      4'd13: return t ? 4'd14 : 4'd13;
      4'd14: return t ? 4'd15 : 4'd11;
      default: return t ? 4'd2 : 4'd1;
    endcase
  endfunction

  function automatic logic m_act();
    return m_claim | dedicated_mode;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h time=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input logic t);
    tms = t;
    scan_tdo = 1'($urandom);
    tdi_pad = 1'($urandom);
    user_tdo_out = 1'($urandom);
    user_tdo_oe = 1'($urandom);
    @(posedge tck); #1;
    if (rst) begin
      m_st = 4'd0; m_claim = 1'b0;
    end else begin
      logic [3:0] n;
      n = nxt(m_st, t);
      if (n == 4'd0) m_claim = 1'b0;
      else if (!m_claim && !t) m_claim = 1'b1;
      m_st = n;
    end
    chk("R3 state", tap_state, m_st);
    chk("R8 onehot", tap_onehot, 16'd1 << m_st);
    chk("R2 active", test_active, m_act());
    chk("R9 pin_en", pin_test_en, {3{m_act()}});
    chk("R9 user_sel", user_sel, {3{~m_act()}});
    chk("R9 scan_tdi", scan_tdi, m_act() ? tdi_pad : 1'b1);
    @(negedge tck); #1;
    if (rst) begin m_dq = 0; m_de = 0; end
    else begin
      m_dq = scan_tdo;
      m_de = m_act() && (m_st == 4'd4 || m_st == 4'd11);
    end
    chk("R6 tdo_out", tdo_pad_out, m_act() ? m_dq : user_tdo_out);
    chk("R6 tdo_oe", tdo_pad_oe, m_act() ? m_de : user_tdo_oe);
  endtask

  task automatic do_reset(input logic ded);
    rst = 1'b1; dedicated_mode = ded;
    tick(1'b1); tick(1'b0);
    chk("R7 reset state", tap_state, 4'd0);
    chk("R7 reset oe", tdo_pad_oe, ded ? 1'b0 : user_tdo_oe);
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge tck);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    m_st = 0; m_claim = 0; m_dq = 0; m_de = 0;
    @(negedge tck); #1;
    do_reset(1'b0);
    tick(1'b1); tick(1'b1);
    chk("R1 no claim while high", test_active, 1'b0);
    tick(1'b0);
    chk("R1 claim on low", test_active, 1'b1);
    chk("R1 state RTI", tap_state, 4'd1);
    tick(1'b1); tick(1'b0); tick(1'b0);
    chk("R6 in shift-dr", tap_state, 4'd4);
    chk("R6 drive in shift", tdo_pad_oe, 1'b1);
    for (int k = 0; k < 4; k++) tick(1'b1);
    chk("R2 held at select-ir", test_active, 1'b1);
    chk("R2 select-ir", tap_state, 4'd9);
    tick(1'b1);
    chk("R4 tlr after five", tap_state, 4'd0);
    chk("R4 released", test_active, 1'b0);

    do_reset(1'b1);
    chk("R5 dedicated in tlr", pin_test_en, 3'b111);
    tick(1'b0); for (int k = 0; k < 5; k++) tick(1'b1);
    chk("R5 dedicated after tlr", test_active, 1'b1);

    for (int blk = 0; blk < 6; blk++) begin
      do_reset(1'($urandom));
      for (int i = 0; i < 600; i++) begin
        if ($urandom % 16 == 0)
          for (int k = 0; k < 5; k++) tick(1'b1);
        else
          tick(($urandom % 3) == 0);
      end
      for (int k = 0; k < 5; k++) tick(1'b1);
      chk("R4 random tlr", tap_state, 4'd0);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule